// File: doc/BRIEF.md
# Universal Shift/Storage Register with Three-State Bus Outputs

This block is a clocked register of `W` bits (eight by default). On each rising clock edge a two-bit mode word selects one of four operations: keep the stored value, shift it toward the high end, shift it toward the low end, or replace it from a parallel data bus. Each shift direction has its own serial input for the bit that enters at the vacated end.

The stored value reaches a shared bus through three-state drivers gated by an active-low enable. Several of these registers can therefore hang on one bus, with at most one enabled at a time. The end bits of the register also appear on two outputs that are always driven. This lets registers be chained through their serial inputs even while their bus drivers are off. A synchronous active-high reset clears the register.

Top module: `shreg_univ`

## Requirements
- R1: When `rst` is 1 at a rising edge, every stored bit becomes 0. This takes priority over every mode and data value.
- R2: With `mode` = 2'b00, the stored value is unchanged across the edge. The parallel and serial inputs are ignored.
- R3: With `mode` = 2'b01, bit i moves to bit i+1 and `ser_r` enters bit 0. `ser_l` is ignored.
- R4: With `mode` = 2'b10, bit i moves to bit i-1 and `ser_l` enters bit W-1. `ser_r` is ignored.
- R5: With `mode` = 2'b11, all W bits are loaded from `par_in` at the edge.
- R6: While `oe_n` is 0, `q_bus` carries the stored value.
- R7: While `oe_n` is 1, every bit of `q_bus` is high impedance, so another driver can own the bus without contention.
- R8: `oe_n` does not affect the register. Shifts and loads proceed while the bus drivers are off, and the result shows once the drivers are enabled.
- R9: `lsb_out` and `msb_out` always carry stored bits 0 and W-1, whatever the value of `oe_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst | input | 1 | Synchronous active-high clear |
| mode | input | 2 | Operation: 00 hold, 01 shift up, 10 shift down, 11 load |
| par_in | input | W | Parallel load data |
| ser_r | input | 1 | Serial bit entering bit 0 on an upward shift |
| ser_l | input | 1 | Serial bit entering bit W-1 on a downward shift |
| oe_n | input | 1 | Active-low enable of the bus drivers |
| q_bus | output | W | Three-state view of the stored value |
| lsb_out | output | 1 | Stored bit 0, always driven |
| msb_out | output | 1 | Stored bit W-1, always driven |

## Verification
The assertions check the next-state rule for every mode, the clear, and the end-bit outputs after a load on every cycle, whether the bus is enabled or not. High impedance on the bus and the absence of contention can only be shown by the scenarios. In those, the bench drives its own value onto the shared bus while the block is disabled, then re-enables the block to reveal state changed in the meantime. Filling the register with eight consecutive shifts in each direction is also exercised only by the scenarios.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  // Bit 0 of the mode word selects the upward shift, bit 1 the downward
  // shift; both together select the parallel load.
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHR  = 2'b01,
    MODE_SHL  = 2'b10,
    MODE_LOAD = 2'b11
  } shift_mode_e;
endpackage

// File: rtl/shreg_mode_dec.sv
module shreg_mode_dec
  import shreg_pkg::*;
(
  input  logic [1:0]  mode_raw,
  output shift_mode_e mode,
  output logic        upd_en
);
  always_comb begin
    mode   = shift_mode_e'(mode_raw);
    upd_en = (mode != MODE_HOLD);
  end
endmodule

// File: rtl/shreg_core.sv
module shreg_core
  import shreg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd_en,
  input  shift_mode_e  mode,
  input  logic [W-1:0] par_in,
  input  logic         ser_r,
  input  logic         ser_l,
  output logic [W-1:0] state_q
);
  localparam int TOP = W - 1;

  logic [W-1:0] next_d;

  always_comb begin
    unique case (mode)
      MODE_SHR:  next_d = {state_q[TOP-1:0], ser_r};
      MODE_SHL:  next_d = {ser_l, state_q[TOP:1]};
      MODE_LOAD: next_d = par_in;
      default:   next_d = state_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      state_q <= '0;
    else if (upd_en)
      state_q <= next_d;
  end
endmodule

// File: rtl/shreg_bus_drv.sv
module shreg_bus_drv #(
  parameter int W = 8
) (
  input  logic         oe_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] bus
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bus[i] = oe_n ? 1'bz : din[i];
  end
endmodule

// File: rtl/shreg_univ.sv
module shreg_univ
  import shreg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode,
  input  logic [W-1:0] par_in,
  input  logic         ser_r,
  input  logic         ser_l,
  input  logic         oe_n,
  output logic [W-1:0] q_bus,
  output logic         lsb_out,
  output logic         msb_out
);
  shift_mode_e  mode_dec;
  logic         upd_en;
  logic [W-1:0] state_q;

  shreg_mode_dec dec_i (
    .mode_raw (mode),
    .mode     (mode_dec),
    .upd_en   (upd_en)
  );

  shreg_core #(.W(W)) core_i (
    .clk     (clk),
    .rst     (rst),
    .upd_en  (upd_en),
    .mode    (mode_dec),
    .par_in  (par_in),
    .ser_r   (ser_r),
    .ser_l   (ser_l),
    .state_q (state_q)
  );

  shreg_bus_drv #(.W(W)) drv_i (
    .oe_n (oe_n),
    .din  (state_q),
    .bus  (q_bus)
  );

  assign lsb_out = state_q[0];
  assign msb_out = state_q[W-1];
endmodule

// File: rtl/shreg_univ_chk.sv
module shreg_univ_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   mode,
  input logic [W-1:0] par_in,
  input logic         ser_r,
  input logic         ser_l,
  input logic         oe_n,
  input logic         lsb_out,
  input logic         msb_out,
  input logic [W-1:0] state_q
);
  assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> state_q == '0);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b00 |=> $stable(state_q));

  assert_shr_R3: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b01 |=> state_q == {$past(state_q[W-2:0]), $past(ser_r)});

  assert_shl_R4: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b10 |=> state_q == {$past(ser_l), $past(state_q[W-1:1])});

  assert_load_R5: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b11 |=> state_q == $past(par_in));

  assert_load_while_off_R8: assert property (@(posedge clk) disable iff (rst)
    (oe_n && mode == 2'b11) |=> state_q == $past(par_in));

  assert_cascade_R9: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b11 |=> (lsb_out == $past(par_in[0])) && (msb_out == $past(par_in[W-1])));
endmodule

bind shreg_univ shreg_univ_chk #(.W(W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .mode    (mode),
  .par_in  (par_in),
  .ser_r   (ser_r),
  .ser_l   (ser_l),
  .oe_n    (oe_n),
  .lsb_out (lsb_out),
  .msb_out (msb_out),
  .state_q (state_q)
);

// File: tb/shreg_univ_tb_top.sv
module shreg_univ_tb_top;
  localparam int W = 8;

  typedef struct packed {
    logic [1:0]   m;
    logic [W-1:0] d;
    logic         sr;
    logic         sl;
    logic [W-1:0] e;
  } vec_t;

  // Walked in order from the value 0x00 left by reset.
  localparam vec_t VECS [0:9] = '{
    '{2'b11, 8'hA5, 1'b0, 1'b0, 8'hA5},  // R5 load
    '{2'b00, 8'hFF, 1'b1, 1'b1, 8'hA5},  // R2 hold
    '{2'b01, 8'h00, 1'b1, 1'b0, 8'h4B},  // R3 shift up, 1 in
    '{2'b01, 8'h00, 1'b0, 1'b1, 8'h96},  // R3 shift up, 0 in, ser_l ignored
    '{2'b10, 8'h00, 1'b0, 1'b1, 8'hCB},  // R4 shift down, 1 in
    '{2'b10, 8'h00, 1'b1, 1'b0, 8'h65},  // R4 shift down, ser_r ignored
    '{2'b11, 8'h3C, 1'b1, 1'b1, 8'h3C},  // R5 load
    '{2'b10, 8'hFF, 1'b1, 1'b0, 8'h1E},  // R4
    '{2'b01, 8'hFF, 1'b0, 1'b1, 8'h3C},  // R3
    '{2'b00, 8'h00, 1'b1, 1'b1, 8'h3C}   // R2 hold
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   mode = 2'b11;
  logic [W-1:0] par_in = 8'hFF;
  logic         ser_r = 1'b1;
  logic         ser_l = 1'b1;
  logic         oe_n = 1'b0;
  logic         lsb_out, msb_out;
  logic         tb_drv_en = 1'b0;
  logic [W-1:0] tb_val = '0;
  wire  [W-1:0] bus_w;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  assign bus_w = tb_drv_en ? tb_val : {W{1'bz}};

  shreg_univ #(.W(W)) dut_i (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .par_in  (par_in),
    .ser_r   (ser_r),
    .ser_l   (ser_l),
    .oe_n    (oe_n),
    .q_bus   (bus_w),
    .lsb_out (lsb_out),
    .msb_out (msb_out)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic [W-1:0] d, input logic sr, input logic sl);
    mode = m; par_in = d; ser_r = sr; ser_l = sl;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    // R1: clear wins over a pending load of all ones.
    @(posedge clk); @(negedge clk);
    check("R1 reset bus", bus_w, 8'h00);
    check("R9 reset ends", {6'b0, msb_out, lsb_out}, 8'h00);
    rst = 1'b0;

    for (int i = 0; i < 10; i++) begin
      step(VECS[i].m, VECS[i].d, VECS[i].sr, VECS[i].sl);
      check($sformatf("R6 vec%0d bus", i), bus_w, VECS[i].e);
      check($sformatf("R9 vec%0d ends", i), {6'b0, msb_out, lsb_out},
            {6'b0, VECS[i].e[W-1], VECS[i].e[0]});
    end

    // R7: block disabled, the bench owns the bus.
    oe_n = 1'b1; tb_val = 8'h5A; tb_drv_en = 1'b1;
    step(2'b00, 8'h00, 1'b0, 1'b0);
    check("R7 bus released", bus_w, 8'h5A);
    check("R9 ends while off", {6'b0, msb_out, lsb_out}, 8'h00);
    // R8: load while drivers are off.
    step(2'b11, 8'hC3, 1'b0, 1'b0);
    check("R7 bus still released", bus_w, 8'h5A);
    check("R9 ends after hidden load", {6'b0, msb_out, lsb_out}, 8'h03);
    tb_drv_en = 1'b0; oe_n = 1'b0;
    step(2'b00, 8'h00, 1'b0, 1'b0);
    check("R8 hidden load visible", bus_w, 8'hC3);

    // R1: clear mid-operation with load requested.
    rst = 1'b1;
    step(2'b11, 8'hFF, 1'b1, 1'b1);
    check("R1 clear over load", bus_w, 8'h00);
    rst = 1'b0;

    // R3: fill with ones from bit 0.
    for (int k = 0; k < 7; k++) step(2'b01, 8'h00, 1'b1, 1'b0);
    check("R3 seven up-shifts", bus_w, 8'h7F);
    check("R9 msb before fill", {7'b0, msb_out}, 8'h00);
    step(2'b01, 8'h00, 1'b1, 1'b0);
    check("R3 eight up-shifts", bus_w, 8'hFF);

    // R4: drain with zeros from bit W-1.
    for (int k = 0; k < 7; k++) step(2'b10, 8'h00, 1'b1, 1'b0);
    check("R4 seven down-shifts", bus_w, 8'h01);
    step(2'b10, 8'h00, 1'b1, 1'b0);
    check("R4 eight down-shifts", bus_w, 8'h00);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule